// File: doc/BRIEF.md
# Lane-Partitioned Population Count and Parity Unit

This combinational unit takes a 64-bit operand and returns either a count of its set bits or a parity bit. A lane-size code picks how the operand is cut up: one 64-bit lane, two 32-bit lanes, or eight 8-bit lanes. Each lane writes its own result into its own slice of the 64-bit output, zero-extended to the width of that slice.

Parity is not taken over every bit. It is taken over the least-significant bit of each byte only. In word mode this gives one bit, and in half mode it gives one bit per 32-bit half. A valid flag goes high in the same cycle as the inputs whenever the combination of operation and lane size is supported. Any other combination drives a zero result with valid low. The unit has no internal state. It sits in an execute stage, and the surrounding pipeline registers its output.

Top module: `lane_popc_parity`

## Requirements
- R1: With op_i = 0 (count) and size_i = 8, result_o equals the number of set bits across all 64 operand bits, zero-extended to 64 bits.
- R2: With op_i = 0 and size_i = 4, result_o[31:0] holds the count of operand[31:0] and result_o[63:32] holds the count of operand[63:32], each zero-extended within its half.
- R3: With op_i = 0 and size_i = 1, each output byte k (bits 8k+7:8k) holds the count of operand byte k, zero-extended within the byte.
- R4: With op_i = 1 (parity) and size_i = 8, result_o[0] is the XOR of operand bits 0, 8, 16, 24, 32, 40, 48 and 56, and all other result bits are 0.
- R5: With op_i = 1 and size_i = 4, result_o[0] is the XOR of operand bits 0, 8, 16 and 24, result_o[32] is the XOR of operand bits 32, 40, 48 and 56, and all other result bits are 0.
- R6: In parity mode, operand bits that are not bit 0 of a byte have no effect on result_o.
- R7: valid_o is 1 in the same cycle for count with size_i of 1, 4 or 8, and for parity with size_i of 4 or 8.
- R8: Every other combination (parity with size_i = 1, or any size_i other than 1, 4 or 8) gives result_o = 0 and valid_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 64 | Source operand |
| op_i | input | 1 | 0 selects count, 1 selects parity |
| size_i | input | 4 | Lane-size code: 1, 4 or 8 |
| result_o | output | 64 | Per-lane results placed in lane positions |
| valid_o | output | 1 | Supported combination selected |

## Verification
The hardest case to reach is a lane count at its upper bound. That takes a full byte giving 8, an all-ones half giving 32, or an all-ones word giving 64, with the neighbouring lanes set to other values so that any spill across a lane edge shows up. Directed patterns reach these bounds on purpose: all ones, alternating full and empty bytes, and a single full half. The parity check against R6 applies pairs of operands that have the same byte LSBs but invert every other bit, and the bench compares the two results. A pseudo-random sweep then covers mixed operands over every size code, including the unsupported ones.

// File: rtl/lpp_pkg.sv
package lpp_pkg;
  localparam int unsigned WORD_W         = 64;
  localparam int unsigned BYTE_W         = 8;
  localparam int unsigned N_BYTES        = WORD_W / BYTE_W;
  localparam int unsigned N_HALVES       = 2;
  localparam int unsigned HALF_W         = WORD_W / N_HALVES;
  localparam int unsigned BYTES_PER_HALF = N_BYTES / N_HALVES;
  localparam int unsigned BC_W           = $clog2(BYTE_W + 1);
  localparam int unsigned HC_W           = $clog2(HALF_W + 1);
  localparam int unsigned WC_W           = $clog2(WORD_W + 1);
  localparam int unsigned SZ_W           = 4;

  localparam logic [SZ_W-1:0] SZ_BYTE = 4'd1;
  localparam logic [SZ_W-1:0] SZ_HALF = 4'd4;
  localparam logic [SZ_W-1:0] SZ_WORD = 4'd8;

  typedef enum logic {
    OP_COUNT  = 1'b0,
    OP_PARITY = 1'b1
  } op_e;

  typedef enum logic [1:0] {
    LANE_NONE = 2'd0,
    LANE_BYTE = 2'd1,
    LANE_HALF = 2'd2,
    LANE_WORD = 2'd3
  } lane_e;
endpackage

// File: rtl/lpp_bit_count.sv
module lpp_bit_count #(
  parameter int unsigned W  = 8,
  parameter int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  bits_i,
  output logic [CW-1:0] count_o
);
  always_comb begin
    count_o = '0;
    for (int i = 0; i < W; i++) count_o = count_o + CW'(bits_i[i]);
  end
endmodule

// File: rtl/lpp_sum_tree.sv
module lpp_sum_tree #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = 4,
  parameter int unsigned OW = 6
) (
  input  logic [N*IW-1:0] parts_i,
  output logic [OW-1:0]   sum_o
);
  always_comb begin
    sum_o = '0;
    for (int i = 0; i < N; i++) sum_o = sum_o + OW'(parts_i[i*IW +: IW]);
  end
endmodule

// File: rtl/lpp_decode.sv
module lpp_decode
  import lpp_pkg::*;
(
  input  logic            op_i,
  input  logic [SZ_W-1:0] size_i,
  output lane_e           lane_o,
  output logic            valid_o
);
  always_comb begin
    lane_o = LANE_NONE;
    unique case (size_i)
      SZ_BYTE: if (op_e'(op_i) == OP_COUNT) lane_o = LANE_BYTE;
      SZ_HALF: lane_o = LANE_HALF;
      SZ_WORD: lane_o = LANE_WORD;
      default: lane_o = LANE_NONE;
    endcase
    valid_o = (lane_o != LANE_NONE);
  end
endmodule

// File: rtl/lane_popc_parity.sv
module lane_popc_parity
  import lpp_pkg::*;
(
  input  logic [WORD_W-1:0] operand_i,
  input  logic              op_i,
  input  logic [SZ_W-1:0]   size_i,
  output logic [WORD_W-1:0] result_o,
  output logic              valid_o
);
  logic [N_BYTES*BC_W-1:0]  byte_cnt;
  logic [N_HALVES*HC_W-1:0] half_cnt;
  logic [WC_W-1:0]          word_cnt;
  logic [N_BYTES-1:0]       byte_lsb;
  logic [N_HALVES-1:0]      half_par;
  logic                     word_par;
  lane_e                    lane;
  logic                     dec_valid;

  lpp_decode u_dec (
    .op_i   (op_i),
    .size_i (size_i),
    .lane_o (lane),
    .valid_o(dec_valid)
  );

  // byte counts feed the half and word sums
  for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
    lpp_bit_count #(.W(BYTE_W), .CW(BC_W)) u_cnt (
      .bits_i (operand_i[b*BYTE_W +: BYTE_W]),
      .count_o(byte_cnt[b*BC_W +: BC_W])
    );
    assign byte_lsb[b] = operand_i[b*BYTE_W];
  end

  for (genvar h = 0; h < N_HALVES; h++) begin : g_half
    lpp_sum_tree #(.N(BYTES_PER_HALF), .IW(BC_W), .OW(HC_W)) u_sum (
      .parts_i(byte_cnt[h*BYTES_PER_HALF*BC_W +: BYTES_PER_HALF*BC_W]),
      .sum_o  (half_cnt[h*HC_W +: HC_W])
    );
    assign half_par[h] = ^byte_lsb[h*BYTES_PER_HALF +: BYTES_PER_HALF];
  end

  lpp_sum_tree #(.N(N_HALVES), .IW(HC_W), .OW(WC_W)) u_word (
    .parts_i(half_cnt),
    .sum_o  (word_cnt)
  );
  assign word_par = ^half_par;

  always_comb begin
    result_o = '0;
    unique case (lane)
      LANE_BYTE: begin
        for (int b = 0; b < N_BYTES; b++)
          result_o[b*BYTE_W +: BC_W] = byte_cnt[b*BC_W +: BC_W];
      end
      LANE_HALF: begin
        for (int h = 0; h < N_HALVES; h++) begin
          if (op_e'(op_i) == OP_PARITY) result_o[h*HALF_W] = half_par[h];
          else result_o[h*HALF_W +: HC_W] = half_cnt[h*HC_W +: HC_W];
        end
      end
      LANE_WORD: begin
        if (op_e'(op_i) == OP_PARITY) result_o[0] = word_par;
        else result_o[WC_W-1:0] = word_cnt;
      end
      default: result_o = '0;
    endcase
  end

  assign valid_o = dec_valid;
endmodule

// File: rtl/lane_popc_parity_chk.sv
module lane_popc_parity_chk
  import lpp_pkg::*;
(
  input logic [WORD_W-1:0] operand_i,
  input logic              op_i,
  input logic [SZ_W-1:0]   size_i,
  input logic [WORD_W-1:0] result_o,
  input logic              valid_o
);
  logic supported;
  assign supported = (size_i == SZ_WORD) || (size_i == SZ_HALF) ||
                     (size_i == SZ_BYTE && !op_i);

  always_comb begin
    if (!op_i && size_i == SZ_WORD)
      AST_WORD_BOUND: assert (result_o <= 64'(WORD_W)); // R1
    if (!op_i && size_i == SZ_HALF) begin
      AST_HALF_LO_BOUND: assert (result_o[HALF_W-1:0] <= 32'(HALF_W)); // R2
      AST_HALF_HI_BOUND: assert (result_o[WORD_W-1:HALF_W] <= 32'(HALF_W)); // R2
    end
    if (!op_i && size_i == SZ_BYTE)
      for (int b = 0; b < N_BYTES; b++)
        AST_BYTE_BOUND: assert (result_o[b*BYTE_W +: BYTE_W] <= 8'(BYTE_W)); // R3
    if (op_i && size_i == SZ_WORD)
      AST_PAR_WORD_SHAPE: assert (result_o[WORD_W-1:1] == '0); // R4
    if (op_i && size_i == SZ_HALF)
      AST_PAR_HALF_SHAPE: assert ((result_o & ~(64'h1 | (64'h1 << HALF_W))) == '0); // R5
    AST_VALID_SUPPORTED: assert (valid_o == supported); // R7
    if (!supported)
      AST_UNSUP_ZERO: assert (result_o == '0); // R8
  end
endmodule

bind lane_popc_parity lane_popc_parity_chk u_chk (
  .operand_i(operand_i),
  .op_i     (op_i),
  .size_i   (size_i),
  .result_o (result_o),
  .valid_o  (valid_o)
);

// File: tb/lane_popc_parity_test.sv
module lane_popc_parity_test;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] operand_i = '0;
  logic        op_i = 1'b0;
  logic [3:0]  size_i = '0;
  logic [63:0] result_o;
  logic        valid_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  lane_popc_parity uut (
    .operand_i(operand_i),
    .op_i     (op_i),
    .size_i   (size_i),
    .result_o (result_o),
    .valid_o  (valid_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > WDOG_CYCLES && !done) begin
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  function automatic void ref_calc(input logic op, input logic [3:0] sz,
                                   input logic [63:0] a,
                                   output logic [63:0] r, output logic v);
    r = '0; v = 1'b0;
    if (!op) begin
      if (sz == 4'd8) begin
        v = 1'b1;
        for (int i = 0; i < 64; i++) r = r + 64'(a[i]);
      end else if (sz == 4'd4) begin
        v = 1'b1;
        for (int i = 0; i < 32; i++) begin
          r[31:0]  = r[31:0]  + 32'(a[i]);
          r[63:32] = r[63:32] + 32'(a[i+32]);
        end
      end else if (sz == 4'd1) begin
        v = 1'b1;
        for (int k = 0; k < 8; k++)
          for (int i = 0; i < 8; i++)
            r[k*8 +: 8] = r[k*8 +: 8] + 8'(a[k*8+i]);
      end
    end else begin
      if (sz == 4'd8) begin
        v = 1'b1;
        for (int k = 0; k < 8; k++) r[0] = r[0] ^ a[k*8];
      end else if (sz == 4'd4) begin
        v = 1'b1;
        for (int k = 0; k < 4; k++) begin
          r[0]  = r[0]  ^ a[k*8];
          r[32] = r[32] ^ a[k*8+32];
        end
      end
    end
  endfunction

  task automatic drive(input logic op, input logic [3:0] sz, input logic [63:0] a);
    @(negedge clk);
    op_i = op; size_i = sz; operand_i = a;
    #1;
  endtask

  task automatic check(input string req, input logic op, input logic [3:0] sz,
                       input logic [63:0] a);
    logic [63:0] er;
    logic ev;
    drive(op, sz, a);
    ref_calc(op, sz, a, er, ev);
    total++;
    if (result_o !== er || valid_o !== ev) begin
      bad++;
      $display("FAIL %s op=%0d size=%0d a=%h: actual=%h/%0b expected=%h/%0b",
               req, op, sz, a, result_o, valid_o, er, ev);
    end
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    total++;
    if (result_o !== '0 || valid_o !== 1'b0) begin
      bad++;
      $display("FAIL R8 idle: actual=%h/%0b expected=0/0", result_o, valid_o);
    end
  endtask

  task automatic t_count_word;
    check("R1", 0, 8, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R1", 0, 8, 64'h0);
    check("R1", 0, 8, 64'h8000_0000_0000_0001);
    check("R1", 0, 8, 64'h0123_4567_89AB_CDEF);
  endtask

  task automatic t_count_half;
    check("R2", 0, 4, 64'h0000_0000_FFFF_FFFF);
    check("R2", 0, 4, 64'hFFFF_FFFF_0000_0000);
    check("R2", 0, 4, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R2", 0, 4, 64'h8000_0001_F0F0_0001);
  endtask

  task automatic t_count_byte;
    check("R3", 0, 1, 64'hFF00_FF00_FF00_FF00);
    check("R3", 0, 1, 64'h00FF_00FF_00FF_00FF);
    check("R3", 0, 1, 64'h0103_070F_1F3F_7FFF);
  endtask

  task automatic t_parity_word;
    check("R4", 1, 8, 64'h0000_0000_0000_0001);
    check("R4", 1, 8, 64'h0101_0101_0101_0101);
    check("R4", 1, 8, 64'h0100_0000_0000_0000);
    check("R4", 1, 8, 64'hFEFE_FEFE_FEFE_FEFE);
  endtask

  task automatic t_parity_half;
    check("R5", 1, 4, 64'h0000_0001_0000_0001);
    check("R5", 1, 4, 64'h0100_0000_0000_0100);
    check("R5", 1, 4, 64'h0001_0101_0101_0000);
    check("R5", 1, 4, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_parity_ignore;
    logic [63:0] base;
    logic [63:0] first;
    logic [63:0] mask;
    mask = 64'h0101_0101_0101_0101;
    base = 64'h0100_0101_0000_0001;
    for (int s = 0; s < 2; s++) begin
      logic [3:0] sz;
      sz = (s == 0) ? 4'd8 : 4'd4;
      check("R6", 1, sz, base);
      first = result_o;
      check("R6", 1, sz, (base & mask) | (~base & ~mask));
      total++;
      if (result_o !== first) begin
        bad++;
        $display("FAIL R6 size=%0d: actual=%h expected=%h", sz, result_o, first);
      end
    end
  endtask

  task automatic t_valid_unsup;
    check("R7", 0, 1, 64'h1);
    check("R7", 1, 8, 64'h1);
    check("R8", 1, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    for (int c = 0; c < 16; c++) begin
      if (c != 1 && c != 4 && c != 8) begin
        check("R8", 0, 4'(c), 64'hFFFF_FFFF_FFFF_FFFF);
        check("R8", 1, 4'(c), 64'hFFFF_FFFF_FFFF_FFFF);
      end
    end
  endtask

  task automatic t_sweep;
    logic [63:0] x;
    x = 64'h9E37_79B9_7F4A_7C15;
    for (int n = 0; n < 300; n++) begin
      x = x ^ (x << 13);
      x = x ^ (x >> 7);
      x = x ^ (x << 17);
      check("R7", x[0], x[4:1], x);
    end
  endtask

  initial begin
    rst_ni = 1'b0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    t_reset_state();
    t_count_word();
    t_count_half();
    t_count_byte();
    t_parity_word();
    t_parity_half();
    t_parity_ignore();
    t_valid_unsup();
    t_sweep();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule